// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a 32-pin general-purpose I/O peripheral on a simple word-wide register bus. Every pin has one bit in each register. Software can load the output latch and the direction register as whole words. It can also change single pins without a read-modify-write, through separate write-one-to-set and write-one-to-clear aliases. A pair of select registers gives each pin a two-bit function code. That code goes to an external pad multiplexer, which chooses between plain GPIO and three alternate functions.

Pin inputs are synchronised into the clock domain. An edge is found by comparing the synchronised level with its value one cycle earlier. Separate rising and falling enables let edges set bits in a sticky interrupt status register, and software clears those bits by writing ones. A second pair of rising and falling masks feeds a sticky wake status. The controller drives one combined interrupt line and one wake line. Two further registers, pull-disable and sleep-control, are plain read/write storage that reaches no pin.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every register, the read data, the interrupt line and the wake line. After reset every pin is a GPIO input with no interrupt or wake source enabled.
- R2: Registers sit at byte offsets 0x00 data, 0x04 data-set, 0x08 data-clear, 0x0C pull-disable, 0x10 direction, 0x14 direction-set, 0x18 direction-clear, 0x1C sleep-control, 0x20 select-A, 0x24 select-B, 0x40 rising enable, 0x44 falling enable, 0x48 interrupt status, 0x4C interrupt clear, 0x50 rising wake mask, 0x54 falling wake mask and 0x58 wake status. A read of 0x0C, 0x10, 0x1C, 0x20, 0x24, 0x40, 0x44, 0x50 or 0x54 returns the word last written there.
- R3: A write to 0x00 loads the output latch. A write to 0x04 sets the latch bits where the word has ones, and a write to 0x08 clears them. Zero bits of either alias leave their latch bits unchanged. `pin_out` shows the latch from the cycle after the write.
- R4: Ones written to 0x14 make those pins outputs (`pin_oe` bit high), and ones written to 0x18 make them inputs. Zero bits have no effect.
- R5: A read of 0x00 returns the synchronised pin levels. A pin change applied before clock edge k is returned by a read strobed at edge k+2 or later.
- R6: `pin_func[2n+1:2n]` equals {select-B bit n, select-A bit n}. 00 is GPIO, 01 is function A, 10 is function B and 11 is function C.
- R7: A rising edge on pin n sets status bit n when rising-enable bit n is 1. A falling edge sets it when falling-enable bit n is 1, and with both enables set either edge sets it. A pin change applied before edge k sets the status after edge k+2. No other status bit is set.
- R8: Writing a one to bit n of 0x4C clears status bit n and the matching wake status bit. If a new qualifying edge is detected at the edge where that clear lands, the bit stays set.
- R9: `irq` is high exactly while some interrupt status bit is set.
- R10: Edges that pass the rising or falling wake mask set sticky wake status bits, readable at 0x58. `wake` is high while any wake status bit is set. Writes to 0x58 are ignored.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Reads of 0x04, 0x08, 0x14, 0x18 and 0x4C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable |
| pin_func | output | 64 | Two-bit function code per pin |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Combined wake indication |

## Verification
Register writes reach `pin_out`, `pin_oe` and `pin_func` one cycle after the write strobe. Read data is due one cycle after the read strobe. Because of the two synchroniser flops and the edge history flop, a pin change becomes visible in a data read two cycles later and in the status, `irq` and `wake` after the third clock edge. The bench's behavioural model keeps a short history of the pin inputs and applies these delays, and every output is compared against it at the falling clock edge. Directed checks then read back status at known points, including a clear timed to land exactly when an edge is detected.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  localparam int PIN_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_DATA    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA_S  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA_C  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PDIS    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DIR_S   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DIR_C   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_SLP     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_SEL_A   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SEL_B   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_EN = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_STAT_C  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_RISE_WK = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_FALL_WK = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_WK_STAT = 8'h58;

  typedef enum logic [1:0] {
    FN_GPIO  = 2'b00,
    FN_ALT_A = 2'b01,
    FN_ALT_B = 2'b10,
    FN_ALT_C = 2'b11
  } pin_fn_e;

  function automatic pin_fn_e fn_code(input logic sel_b, input logic sel_a);
    return pin_fn_e'({sel_b, sel_a});
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pin_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  AST_LEVEL_HIST: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_q == $past(level_o)))  // R5
    else $error("edge history does not follow level");
endmodule

// File: rtl/gpio_event_reg.sv
module gpio_event_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic         any_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;
  logic         any_q;

  assign status_d = (status_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      any_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      any_q    <= |status_d;
    end
  end

  assign status_o = status_q;
  assign any_o    = any_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)))  // R8
    else $error("new event lost");
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0))  // R7
    else $error("status bit set without event");
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
    any_q == (status_q != '0))  // R9
    else $error("combined line disagrees with status");
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int PINS        = PIN_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [2*PINS-1:0] pin_func,
  output logic              irq,
  output logic              wake
);
  logic [PINS-1:0] out_q, dir_q, pdis_q, slp_q, sela_q, selb_q;
  logic [PINS-1:0] ren_q, fen_q, rwk_q, fwk_q;
  logic [PINS-1:0] level, rise, fall;
  logic [PINS-1:0] irq_set, wk_set, ev_clr, irq_stat, wk_stat;
  logic [PINS-1:0] rdata_q;

  gpio_pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  assign irq_set = (rise & ren_q) | (fall & fen_q);
  assign wk_set  = (rise & rwk_q) | (fall & fwk_q);
  assign ev_clr  = (bus_wr && bus_addr == OFS_STAT_C) ? bus_wdata : '0;

  gpio_event_reg #(.W(PINS)) u_irq_ev (
    .clk(clk), .rst(rst), .set_i(irq_set), .clr_i(ev_clr),
    .status_o(irq_stat), .any_o(irq)
  );

  gpio_event_reg #(.W(PINS)) u_wake_ev (
    .clk(clk), .rst(rst), .set_i(wk_set), .clr_i(ev_clr),
    .status_o(wk_stat), .any_o(wake)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0; dir_q  <= '0; pdis_q <= '0; slp_q <= '0;
      sela_q <= '0; selb_q <= '0; ren_q  <= '0; fen_q <= '0;
      rwk_q  <= '0; fwk_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DATA:    out_q  <= bus_wdata;
        OFS_DATA_S:  out_q  <= out_q | bus_wdata;
        OFS_DATA_C:  out_q  <= out_q & ~bus_wdata;
        OFS_PDIS:    pdis_q <= bus_wdata;
        OFS_DIR:     dir_q  <= bus_wdata;
        OFS_DIR_S:   dir_q  <= dir_q | bus_wdata;
        OFS_DIR_C:   dir_q  <= dir_q & ~bus_wdata;
        OFS_SLP:     slp_q  <= bus_wdata;
        OFS_SEL_A:   sela_q <= bus_wdata;
        OFS_SEL_B:   selb_q <= bus_wdata;
        OFS_RISE_EN: ren_q  <= bus_wdata;
        OFS_FALL_EN: fen_q  <= bus_wdata;
        OFS_RISE_WK: rwk_q  <= bus_wdata;
        OFS_FALL_WK: fwk_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_DATA:    rdata_q <= level;
        OFS_PDIS:    rdata_q <= pdis_q;
        OFS_DIR:     rdata_q <= dir_q;
        OFS_SLP:     rdata_q <= slp_q;
        OFS_SEL_A:   rdata_q <= sela_q;
        OFS_SEL_B:   rdata_q <= selb_q;
        OFS_RISE_EN: rdata_q <= ren_q;
        OFS_FALL_EN: rdata_q <= fen_q;
        OFS_STAT:    rdata_q <= irq_stat;
        OFS_RISE_WK: rdata_q <= rwk_q;
        OFS_FALL_WK: rdata_q <= fwk_q;
        OFS_WK_STAT: rdata_q <= wk_stat;
        default:     rdata_q <= '0;
      endcase
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_func
    assign pin_func[2*n +: 2] = fn_code(selb_q[n], sela_q[n]);
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;

  AST_DIR_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DIR_S) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)))  // R4
    else $error("direction set ignored");
  AST_DATA_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DATA_C) |=> ((pin_out & $past(bus_wdata)) == '0))  // R3
    else $error("data clear ignored");
  AST_DATA_SET_KEEP: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DATA_S) |=> ((pin_out & $past(pin_out)) == $past(pin_out)))  // R3
    else $error("data set cleared a bit");
  AST_ALIAS_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_STAT_C) |=> (bus_rdata == '0))  // R11
    else $error("clear alias read not zero");
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata))  // R11
    else $error("read data moved without strobe");
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic [63:0] pin_func;
  logic        irq, wake;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .irq(irq), .wake(wake)
  );

  // behavioural reference
  logic [31:0] m_out, m_dir, m_pdis, m_slp, m_sa, m_sb, m_ren, m_fen, m_rwk, m_fwk;
  logic [31:0] m_st, m_wk, m_rd;
  logic [31:0] hist[$];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return hist[1];
      8'h0C: return m_pdis;  8'h10: return m_dir;  8'h1C: return m_slp;
      8'h20: return m_sa;    8'h24: return m_sb;   8'h40: return m_ren;
      8'h44: return m_fen;   8'h48: return m_st;   8'h50: return m_rwk;
      8'h54: return m_fwk;   8'h58: return m_wk;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_out, m_dir, m_pdis, m_slp, m_sa, m_sb} = '0;
      {m_ren, m_fen, m_rwk, m_fwk, m_st, m_wk, m_rd} = '0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] up, dn, clr, ist, iwk;
      up  = hist[1] & ~hist[2];
      dn  = ~hist[1] & hist[2];
      ist = (up & m_ren) | (dn & m_fen);
      iwk = (up & m_rwk) | (dn & m_fwk);
      clr = 32'h0;
      if (bus_rd) m_rd = m_read(bus_addr);
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_out = bus_wdata;
          8'h04: m_out = m_out | bus_wdata;
          8'h08: m_out = m_out & ~bus_wdata;
          8'h0C: m_pdis = bus_wdata;
          8'h10: m_dir = bus_wdata;
          8'h14: m_dir = m_dir | bus_wdata;
          8'h18: m_dir = m_dir & ~bus_wdata;
          8'h1C: m_slp = bus_wdata;
          8'h20: m_sa = bus_wdata;
          8'h24: m_sb = bus_wdata;
          8'h40: m_ren = bus_wdata;
          8'h44: m_fen = bus_wdata;
          8'h4C: clr = bus_wdata;
          8'h50: m_rwk = bus_wdata;
          8'h54: m_fwk = bus_wdata;
          default: ;
        endcase
      end
      m_st = (m_st & ~clr) | ist;
      m_wk = (m_wk & ~clr) | iwk;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_func();
    logic [63:0] f;
    for (int n = 0; n < 32; n++) f[2*n +: 2] = {m_sb[n], m_sa[n]};
    return f;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R11 rdata", {32'h0, bus_rdata}, {32'h0, m_rd});
      check("R3 pin_out", {32'h0, pin_out}, {32'h0, m_out});
      check("R4 pin_oe", {32'h0, pin_oe}, {32'h0, m_dir});
      check("R6 pin_func", pin_func, exp_func());
      check("R9 irq", {63'h0, irq}, {63'h0, (m_st != 0)});
      check("R10 wake", {63'h0, wake}, {63'h0, (m_wk != 0)});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 out", {32'h0, pin_out}, 64'h0);
    check("R1 oe", {32'h0, pin_oe}, 64'h0);
    check("R1 func", pin_func, 64'h0);
    check("R1 irq/wake", {62'h0, irq, wake}, 64'h0);
    rd(8'h40); check("R1 rise_en", {32'h0, bus_rdata}, 64'h0);

    // R2: storage registers read back
    wr(8'h0C, 32'hA5A5_0001); wr(8'h1C, 32'h0F0F_1234);
    rd(8'h0C); check("R2 pull-disable", {32'h0, bus_rdata}, 64'hA5A5_0001);
    rd(8'h1C); check("R2 sleep", {32'h0, bus_rdata}, 64'h0F0F_1234);
    wr(8'h54, 32'h8000_0000);
    rd(8'h54); check("R2 fall wake", {32'h0, bus_rdata}, 64'h8000_0000);
    wr(8'h54, 32'h0);

    // R3: data latch and aliases
    wr(8'h00, 32'hF0F0_0000); check("R3 load", {32'h0, pin_out}, 64'hF0F0_0000);
    wr(8'h04, 32'h0000_000F); check("R3 set", {32'h0, pin_out}, 64'hF0F0_000F);
    wr(8'h08, 32'hF000_0000); check("R3 clear", {32'h0, pin_out}, 64'h00F0_000F);

    // R4: direction aliases
    wr(8'h14, 32'h0000_00FF); wr(8'h14, 32'h0000_0F00);
    check("R4 set", {32'h0, pin_oe}, 64'h0000_0FFF);
    wr(8'h18, 32'h0000_0011); check("R4 clear", {32'h0, pin_oe}, 64'h0000_0FEE);
    rd(8'h10); check("R4 readback", {32'h0, bus_rdata}, 64'h0000_0FEE);

    // R6: function code per pin
    wr(8'h20, 32'h5); wr(8'h24, 32'h6);
    check("R6 func", pin_func, 64'h39);

    // R5: synchronised level read, two-cycle latency
    pin_in = 32'h0000_1234;
    rd(8'h00); check("R5 too early", {32'h0, bus_rdata}, 64'h0);
    rd(8'h00); check("R5 still early", {32'h0, bus_rdata}, 64'h0);
    rd(8'h00); check("R5 visible", {32'h0, bus_rdata}, 64'h0000_1234);
    pin_in = 32'h0; idle(4);

    // R7/R8/R9: edge interrupts
    wr(8'h40, 32'h0000_0005); wr(8'h44, 32'h0000_0006);
    pin_in = 32'h0000_0001; idle(2);
    check("R7 not yet", {63'h0, irq}, 64'h0);
    idle(1);
    check("R7 rising sets", {63'h0, irq}, 64'h1);
    pin_in = 32'h0000_0003; idle(4);
    rd(8'h48); check("R7 rise on fall-only pin", {32'h0, bus_rdata}, 64'h1);
    pin_in = 32'h0000_0001; idle(4);
    rd(8'h48); check("R7 falling sets", {32'h0, bus_rdata}, 64'h3);
    pin_in = 32'h0000_0005; idle(4);
    pin_in = 32'h0000_0001; idle(4);
    rd(8'h48); check("R7 either edge", {32'h0, bus_rdata}, 64'h7);
    wr(8'h4C, 32'h1);
    rd(8'h48); check("R8 clear one", {32'h0, bus_rdata}, 64'h6);
    check("R9 still high", {63'h0, irq}, 64'h1);
    wr(8'h4C, 32'h6);
    check("R9 low", {63'h0, irq}, 64'h0);

    // R8: clear colliding with a new edge
    pin_in = 32'h0000_0005; idle(2);
    wr(8'h4C, 32'h4);
    rd(8'h48); check("R8 set wins", {32'h0, bus_rdata}, 64'h4);
    wr(8'h4C, 32'h4);
    rd(8'h48); check("R8 cleared", {32'h0, bus_rdata}, 64'h0);

    // R10: wake masks, read-only status
    wr(8'h50, 32'h0000_0010);
    pin_in = 32'h0000_0015; idle(4);
    check("R10 wake high", {63'h0, wake}, 64'h1);
    check("R10 irq unaffected", {63'h0, irq}, 64'h0);
    wr(8'h58, 32'h0);
    rd(8'h58); check("R10 write ignored", {32'h0, bus_rdata}, 64'h10);
    wr(8'h4C, 32'h10);
    check("R10 cleared", {63'h0, wake}, 64'h0);

    // R11: alias reads and hold
    rd(8'h04); check("R11 alias zero", {32'h0, bus_rdata}, 64'h0);
    rd(8'h24); idle(3);
    check("R11 hold", {32'h0, bus_rdata}, 64'h6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule